// File: doc/BRIEF.md
# Second-Level Map Block Allocator with Clock Scan

This block hands out second-level translation blocks to first-level translation entries that have missed. It holds a first-level table, where each entry has a valid flag and a block number, and a reverse table with one record per second-level block. Each reverse record names the first-level entry that owns the block, or is marked free. A miss request carries the index of the first-level entry that missed. The block answers with a one-cycle completion pulse that carries the block number now bound to that entry, plus a flag that says whether a new block had to be found.

If the missing entry is still the recorded owner of the block it points at, the block only sets the entry's valid flag again. In every other case a clock hand walks the reverse table. A free block is taken at once. A block whose owner has already lost its valid flag is taken from that owner. An owner whose valid flag is still set gets a second chance: the flag is cleared and the hand moves on. The hand wraps around, so one full pass without a winner means the next pass is sure to find a block. The hand keeps its position between requests. Filling the newly allocated block with entries belongs to the surrounding logic.

After reset, the block spends a sweep writing every first-level entry invalid and every reverse record free. It accepts requests only while `ready` is high.

Top module: `l2blk_clock_alloc`

## Requirements
- R1: After reset, `ready` and `done` are low during an initialisation sweep. Once `ready` rises, every block is free, every first-level entry is invalid and the hand points at block 0. The first request therefore receives block 0 with `done_new` = 1.
- R2: Suppose the reverse record of the block named in the requesting entry names that same entry. Then the reply is that block with `done_new` = 0, the entry becomes valid, and the hand does not move.
- R3: During a scan, a block whose reverse record is free is taken immediately, with `done_new` = 1.
- R4: During a scan, a block whose owner entry has its valid flag clear is taken from that owner. A later request from the former owner then receives a new block.
- R5: During a scan, an owner whose valid flag is set has that flag cleared and keeps its block, and the hand advances by one. A later request from that owner takes the quick path of R2.
- R6: The hand wraps from block 2^BLK_AW-1 to block 0. When every block is owned by a valid entry, one full pass ages them all, and the block at the starting position is then taken.
- R7: An allocation writes the block number into the requesting entry and sets the entry valid. It also records the requester as the owner of that block.
- R8: After an allocation, the hand points at the block that follows the allocated block, modulo 2^BLK_AW. The next scan starts there.
- R9: Latency is counted from the accepting clock edge to the edge that raises `done`, including both edges. The quick path takes 3 edges. A scan takes 4 edges, plus 2 for each owner it ages, plus 1 if the block is taken from an invalid owner.
- R10: `ready` is high only when the block is idle. A request presented while `ready` is low is ignored and leaves no trace.
- R11: `done` is high for exactly one cycle per accepted request, and `done_blk` and `done_new` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request, taken when `ready` is high |
| req_idx | input | L1_AW | Index of the first-level entry that missed |
| ready | output | 1 | Block is idle and accepts a request |
| done | output | 1 | One-cycle completion pulse |
| done_blk | output | BLK_AW | Block number now bound to the entry |
| done_new | output | 1 | 1 if a new block was allocated, 0 for re-validation only |

## Verification
The bound checker enforces the handshake rules on every cycle: `done` is a single-cycle pulse, no completion appears while the block is busy, and `ready` falls after it accepts a request and stays high while it is idle. The checker also confirms that after each fresh allocation the hand sits one block past the allocated one. Which block is chosen, whether owners are aged or robbed, wrap-around after a full pass, and the exact latency can only be shown by the bench. It tracks both tables and the hand through long request sequences on a 16-entry, 4-block configuration, and it repeats a reset partway through the run.

// File: rtl/l2blk_pkg.sv
package l2blk_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_RD_L1,
    ST_CHK_OWN,
    ST_SCAN_REV,
    ST_SCAN_L1
  } alloc_state_e;

endpackage

// File: rtl/l2blk_spram.sv
// Single-port synchronous RAM: one read or one write per cycle, registered read.
module l2blk_spram #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/l2blk_init_seq.sv
// Walks an address counter over the whole first-level table after reset.
module l2blk_init_seq #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic          active,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      addr   <= '0;
    end else if (active) begin
      addr <= addr + 1'b1;
      if (&addr) active <= 1'b0;
    end
  end
endmodule

// File: rtl/l2blk_clock_alloc.sv
module l2blk_clock_alloc #(
  parameter int L1_AW  = 12,
  parameter int BLK_AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [L1_AW-1:0]  req_idx,
  output logic              ready,
  output logic              done,
  output logic [BLK_AW-1:0] done_blk,
  output logic              done_new
);
  import l2blk_pkg::*;

  localparam int L1W  = 1 + BLK_AW;  // {valid, block}
  localparam int REVW = 1 + L1_AW;   // {free, owner}

  alloc_state_e      state_q;
  logic [L1_AW-1:0]  idx_q;
  logic [L1_AW-1:0]  owner_q;
  logic [BLK_AW-1:0] blk_q;
  logic [BLK_AW-1:0] hand_q;
  logic              done_q;
  logic [BLK_AW-1:0] done_blk_q;
  logic              done_new_q;

  logic              init_active;
  logic [L1_AW-1:0]  init_addr;

  logic              l1_en, l1_we;
  logic [L1_AW-1:0]  l1_addr;
  logic [L1W-1:0]    l1_wd, l1_rd;
  logic              rev_en, rev_we;
  logic [BLK_AW-1:0] rev_addr;
  logic [REVW-1:0]   rev_wd, rev_rd;

  logic              l1_rd_v;
  logic [BLK_AW-1:0] l1_rd_blk;
  logic              rev_rd_free;
  logic [L1_AW-1:0]  rev_rd_own;
  logic              quick, take;

  assign l1_rd_v     = l1_rd[L1W-1];
  assign l1_rd_blk   = l1_rd[BLK_AW-1:0];
  assign rev_rd_free = rev_rd[REVW-1];
  assign rev_rd_own  = rev_rd[L1_AW-1:0];

  l2blk_init_seq #(.AW(L1_AW)) u_init (
    .clk    (clk),
    .rst    (rst),
    .active (init_active),
    .addr   (init_addr)
  );

  l2blk_spram #(.W(L1W), .AW(L1_AW)) u_l1_tab (
    .clk   (clk),
    .en    (l1_en),
    .we    (l1_we),
    .addr  (l1_addr),
    .wdata (l1_wd),
    .rdata (l1_rd)
  );

  l2blk_spram #(.W(REVW), .AW(BLK_AW)) u_rev_tab (
    .clk   (clk),
    .en    (rev_en),
    .we    (rev_we),
    .addr  (rev_addr),
    .wdata (rev_wd),
    .rdata (rev_rd)
  );

  // Decisions for the current state, from the registered RAM outputs.
  always_comb begin
    quick = 1'b0;
    take  = 1'b0;
    case (state_q)
      ST_CHK_OWN:  quick = !rev_rd_free && (rev_rd_own == idx_q);
      ST_SCAN_REV: take  = rev_rd_free;
      ST_SCAN_L1:  take  = !l1_rd_v;
      default: ;
    endcase
  end

  // Table port control: at most one access per table per cycle.
  always_comb begin
    l1_en    = 1'b0;
    l1_we    = 1'b0;
    l1_addr  = idx_q;
    l1_wd    = '0;
    rev_en   = 1'b0;
    rev_we   = 1'b0;
    rev_addr = hand_q;
    rev_wd   = '0;
    if (take) begin
      l1_en    = 1'b1;
      l1_we    = 1'b1;
      l1_addr  = idx_q;
      l1_wd    = {1'b1, hand_q};
      rev_en   = 1'b1;
      rev_we   = 1'b1;
      rev_addr = hand_q;
      rev_wd   = {1'b0, idx_q};
    end else begin
      case (state_q)
        ST_INIT: begin
          l1_en    = init_active;
          l1_we    = 1'b1;
          l1_addr  = init_addr;
          l1_wd    = '0;
          rev_en   = init_active && ((init_addr >> BLK_AW) == '0);
          rev_we   = 1'b1;
          rev_addr = init_addr[BLK_AW-1:0];
          rev_wd   = {1'b1, {L1_AW{1'b0}}};
        end
        ST_IDLE: begin
          l1_en   = req_valid;
          l1_addr = req_idx;
        end
        ST_RD_L1: begin
          rev_en   = 1'b1;
          rev_addr = l1_rd_blk;
        end
        ST_CHK_OWN: begin
          if (quick) begin
            l1_en   = 1'b1;
            l1_we   = 1'b1;
            l1_addr = idx_q;
            l1_wd   = {1'b1, blk_q};
          end else begin
            rev_en   = 1'b1;
            rev_addr = hand_q;
          end
        end
        ST_SCAN_REV: begin
          l1_en   = 1'b1;
          l1_addr = rev_rd_own;
        end
        ST_SCAN_L1: begin
          // Second chance: clear the owner's valid flag, look at the next block.
          l1_en    = 1'b1;
          l1_we    = 1'b1;
          l1_addr  = owner_q;
          l1_wd    = {1'b0, l1_rd_blk};
          rev_en   = 1'b1;
          rev_addr = hand_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_INIT;
      idx_q      <= '0;
      owner_q    <= '0;
      blk_q      <= '0;
      hand_q     <= '0;
      done_q     <= 1'b0;
      done_blk_q <= '0;
      done_new_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        done_q     <= 1'b1;
        done_blk_q <= hand_q;
        done_new_q <= 1'b1;
        hand_q     <= hand_q + 1'b1;
        state_q    <= ST_IDLE;
      end else begin
        case (state_q)
          ST_INIT: if (!init_active) state_q <= ST_IDLE;
          ST_IDLE: begin
            if (req_valid) begin
              idx_q   <= req_idx;
              state_q <= ST_RD_L1;
            end
          end
          ST_RD_L1: begin
            blk_q   <= l1_rd_blk;
            state_q <= ST_CHK_OWN;
          end
          ST_CHK_OWN: begin
            if (quick) begin
              done_q     <= 1'b1;
              done_blk_q <= blk_q;
              done_new_q <= 1'b0;
              state_q    <= ST_IDLE;
            end else begin
              state_q <= ST_SCAN_REV;
            end
          end
          ST_SCAN_REV: begin
            owner_q <= rev_rd_own;
            state_q <= ST_SCAN_L1;
          end
          ST_SCAN_L1: begin
            hand_q  <= hand_q + 1'b1;
            state_q <= ST_SCAN_REV;
          end
          default: state_q <= ST_INIT;
        endcase
      end
    end
  end

  assign ready    = (state_q == ST_IDLE);
  assign done     = done_q;
  assign done_blk = done_blk_q;
  assign done_new = done_new_q;

endmodule

// File: rtl/l2blk_clock_alloc_chk.sv
module l2blk_clock_alloc_chk #(
  parameter int BLK_AW = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              ready,
  input logic              done,
  input logic              done_new,
  input logic [BLK_AW-1:0] done_blk,
  input logic [BLK_AW-1:0] hand
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_no_done_busy_r10: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !done);

  p_accept_drop_r10: assert property (@(posedge clk) disable iff (rst)
    ready && req_valid |=> !ready);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ready && !req_valid |=> ready);

  p_hand_next_r8: assert property (@(posedge clk) disable iff (rst)
    done && done_new |-> hand == BLK_AW'(done_blk + 1'b1));
endmodule

bind l2blk_clock_alloc l2blk_clock_alloc_chk #(.BLK_AW(BLK_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .ready     (ready),
  .done      (done),
  .done_new  (done_new),
  .done_blk  (done_blk),
  .hand      (hand_q)
);

// File: tb/l2blk_clock_alloc_tb.sv
module l2blk_clock_alloc_tb;
  localparam int L1_AW  = 4;
  localparam int BLK_AW = 2;
  localparam int NL1    = 1 << L1_AW;
  localparam int NB     = 1 << BLK_AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [L1_AW-1:0]  req_idx = '0;
  logic              ready, done, done_new;
  logic [BLK_AW-1:0] done_blk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench view of both tables and the hand.
  bit m_free [NB];
  int m_own  [NB];
  bit m_v    [NL1];
  int m_b    [NL1];
  int m_hand;

  always #5 clk = ~clk;

  l2blk_clock_alloc #(.L1_AW(L1_AW), .BLK_AW(BLK_AW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .ready(ready), .done(done), .done_blk(done_blk), .done_new(done_new)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_free[b] = 1; m_own[b] = 0; end
    for (int i = 0; i < NL1; i++) begin m_v[i] = 0; m_b[i] = 0; end
    m_hand = 0;
  endtask

  task automatic do_reset();
    int w;
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready low during init", ready, 0);
    chk(done == 1'b0, "R1 done low during init", done, 0);
    w = 0;
    while (!ready && w < NL1 + 10) begin @(negedge clk); w++; end
    chk(ready == 1'b1, "R1 ready after init sweep", ready, 1);
  endtask

  // Issue one request; compare block, new flag and latency with the model.
  task automatic do_req(input int idx, input string tag, input bit inject);
    int exp_blk, exp_lat, lat, h, extra;
    bit exp_new, q;
    q = !m_free[m_b[idx]] && (m_own[m_b[idx]] == idx);
    if (q) begin
      m_v[idx] = 1; exp_blk = m_b[idx]; exp_new = 0; exp_lat = 3;
    end else begin
      exp_lat = 4; exp_new = 1;
      forever begin
        h = m_hand;
        if (m_free[h]) break;
        if (!m_v[m_own[h]]) begin exp_lat += 1; break; end
        m_v[m_own[h]] = 0;  // aged
        exp_lat += 2;
        m_hand = (m_hand + 1) % NB;
      end
      exp_blk = h;
      m_v[idx] = 1; m_b[idx] = h;
      m_free[h] = 0; m_own[h] = idx;
      m_hand = (h + 1) % NB;
    end
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1;
    req_idx = L1_AW'(idx);
    @(posedge clk);
    lat = 1;
    forever begin
      @(negedge clk);
      if (lat == 1) req_valid = 1'b0;
      if (inject && lat == 2) begin req_valid = 1'b1; req_idx = L1_AW'(NL1 - 1 - idx); end
      if (inject && lat == 3) req_valid = 1'b0;
      if (done || lat > 200) break;
      @(posedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk(done == 1'b1, {tag, " done seen"}, done, 1);
    chk(int'(done_blk) == exp_blk, {tag, " block"}, done_blk, exp_blk);
    chk(done_new == exp_new, {tag, " new flag"}, done_new, exp_new);
    chk(lat == exp_lat, {tag, " R9 latency"}, lat, exp_lat);
    @(negedge clk);
    chk(done == 1'b0, "R11 single-cycle done", done, 0);
    if (inject) begin
      extra = 0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); if (done) extra++; end
      chk(extra == 0, "R10 busy request ignored", extra, 0);
    end
  endtask

  initial begin
    do_reset();
    // R1 R3 R8: fresh blocks handed out in hand order.
    for (int i = 0; i < NB; i++) do_req(i, "R3 free block", 0);
    // R2: owners re-request, quick path.
    for (int i = 0; i < NB; i++) do_req(i, "R2 quick path", 0);
    // R5 R6: all owners valid, full pass ages them all, start block taken.
    do_req(NB, "R6 full pass wrap", 0);
    // R4: next owner was aged, its block is taken.
    do_req(NB + 1, "R4 steal invalid owner", 0);
    // R5: aged but still owning, quick path.
    do_req(2, "R5 aged owner revalidates", 0);
    // R4 R7: robbed owner gets a new block.
    do_req(0, "R7 robbed owner reallocates", 0);
    // R10: request while busy is dropped.
    do_req(9, "R10 scan with injection", 1);
    // Sweep patterns.
    for (int r = 0; r < 6; r++)
      for (int i = 0; i < NL1; i++)
        do_req((i * 7 + r * 3) % NL1, "R7 sweep", (i % 5) == 0);
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < NB + 1; i++)
        do_req(i + r, "R8 tight loop", 0);
    // R1: reset again, old owners gone.
    do_reset();
    do_req(3, "R1 after second reset", 0);
    do_req(3, "R2 after second reset", 0);
    for (int i = 0; i < NL1; i++) do_req(NL1 - 1 - i, "R6 reverse sweep", 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule